// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block turns the peripheral clock into the serial-clock timing for an I2C master's bit engine. Two programmable prescalers run in cascade. The first divides by (A+1) and enables the second. The second divides by (B+1) and yields a base tick. A phase sequencer then spends 22 base ticks on every serial-clock period: 11 with the line low and 11 with it high. The result is a serial-clock period of 22 × (A+1) × (B+1) input clocks. Even with both divisors at zero, the rate cannot exceed the input clock divided by 22.

Alongside the serial-clock level, the block gives the bit engine single-cycle strobes:
- a falling-edge strobe;
- a mid-low strobe, where the bit engine may change the data line;
- a rising-edge strobe;
- a mid-high strobe, where the bit engine samples.

It also outputs the raw base tick. Divisor values from the control-register fields are captured only while the transfer-busy input is low, so a running transfer keeps its timing. Dropping the enable clears every counter, and the next enable starts a fresh period with the line low. All pins are plain control and status lines with no handshake, because no data stream crosses this block's boundary.

Top module: `scl_rate_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, scl_o is 1 and tick_o, fall_o, drive_o, rise_o and sample_o are all 0.
- R2: While en_i is low, scl_o is 1 and no strobe output is ever 1, from the cycle after en_i is seen low.
- R3: With the divisors held, the spacing between successive fall_o pulses is exactly 22 × (A+1) × (B+1) clock cycles, where A is div_a_i (2 bits, values 0..3) and B is div_b_i (6 bits, values 0..63).
- R4: Within a period, rise_o comes 11 × P cycles after fall_o, where P = (A+1)(B+1), and the next fall_o comes 11 × P cycles after rise_o. scl_o is 1 in every cycle in which rise_o is 1 and 0 in every cycle in which fall_o is 1.
- R5: drive_o pulses 5 × P cycles after the start of each low phase, and sample_o pulses 5 × P cycles after each rise_o.
- R6: tick_o pulses once every P cycles while enabled, and every phase strobe coincides with a tick_o pulse.
- R7: div_a_i and div_b_i are captured only in cycles where busy_i is 0. Values presented while busy_i is 1 have no effect on any later period.
- R8: Counting starts from zero on enable. In the first cycle after en_i is seen high, scl_o goes to 0. drive_o follows 5 × P cycles later and rise_o follows 11 × P cycles later.
- R9: At most one of fall_o, drive_o, rise_o and sample_o is 1 in any cycle.
- R10: With A = 0 and B = 0, the period is the fastest possible: 22 cycles between fall_o pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Run the generator; low clears all counters |
| busy_i | input | 1 | Transfer in progress; high freezes the captured divisors |
| div_a_i | input | 2 | First-stage divisor field, divides by value+1 |
| div_b_i | input | 6 | Second-stage divisor field, divides by value+1 |
| scl_o | output | 1 | Serial-clock level, 1 when idle |
| tick_o | output | 1 | Base tick, one pulse per (A+1)(B+1) cycles |
| fall_o | output | 1 | Serial clock has just gone low |
| drive_o | output | 1 | Middle of the low phase |
| rise_o | output | 1 | Serial clock has just gone high |
| sample_o | output | 1 | Middle of the high phase |

## Verification
If either prescaler counter miscounts, every base tick drifts by the error. At the ports this shows up within one period of P cycles as a wrong tick_o spacing, and within 22 × P cycles as a wrong fall-to-fall interval. A corrupted phase counter moves the strobes off their 5P, 11P and 16P offsets, or makes two strobes coincide. This is visible on the first low or high phase after the fault. A divisor capture that ignores busy_i shows up as a changed period on the very next full period measured while busy_i is held high.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;
  localparam int DIV_A_W    = 2;
  localparam int DIV_B_W    = 6;
  localparam int LOW_TICKS  = 11;
  localparam int HIGH_TICKS = 11;

  typedef struct packed {
    logic tick;
    logic fall;
    logic drive;
    logic rise;
    logic sample;
  } strobe_t;
endpackage

// File: rtl/scl_div_capture.sv
module scl_div_capture #(
  parameter int AW = 2,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic [AW-1:0] a_i,
  input  logic [BW-1:0] b_i,
  output logic [AW-1:0] a_q,
  output logic [BW-1:0] b_q
);
  // Divisors are sampled only when no transfer is running.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (!busy_i) begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end
endmodule

// File: rtl/scl_prescale_stage.sv
module scl_prescale_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  // Greater-or-equal keeps the stage safe if the limit shrinks mid-count.
  assign wrap_o = step_i && (cnt_q >= limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_rate_pkg::*;
#(
  parameter int LOW  = LOW_TICKS,
  parameter int HIGH = HIGH_TICKS
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    run_i,
  input  logic    active_i,
  input  logic    tick_i,
  output strobe_t strb_o,
  output logic    scl_o
);
  localparam int TOTAL = LOW + HIGH;
  localparam int PH_W  = $clog2(TOTAL);
  localparam logic [PH_W-1:0] PH_LAST     = PH_W'(TOTAL - 1);
  localparam logic [PH_W-1:0] PH_PRE_RISE = PH_W'(LOW - 1);
  localparam logic [PH_W-1:0] PH_PRE_DRV  = PH_W'(LOW / 2 - 1);
  localparam logic [PH_W-1:0] PH_PRE_SMP  = PH_W'(LOW + HIGH / 2 - 1);
  localparam logic [PH_W-1:0] PH_LOW      = PH_W'(LOW);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !active_i) begin
      ph_q   <= '0;
      strb_o <= '0;
    end else begin
      strb_o.tick   <= tick_i;
      strb_o.fall   <= tick_i && (ph_q == PH_LAST);
      strb_o.rise   <= tick_i && (ph_q == PH_PRE_RISE);
      strb_o.drive  <= tick_i && (ph_q == PH_PRE_DRV);
      strb_o.sample <= tick_i && (ph_q == PH_PRE_SMP);
      if (tick_i) begin
        ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end
    end
  end

  assign scl_o = ~(run_i && (ph_q < PH_LOW));
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_rate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               busy_i,
  input  logic [DIV_A_W-1:0] div_a_i,
  input  logic [DIV_B_W-1:0] div_b_i,
  output logic               scl_o,
  output logic               tick_o,
  output logic               fall_o,
  output logic               drive_o,
  output logic               rise_o,
  output logic               sample_o
);
  logic [DIV_A_W-1:0] a_q;
  logic [DIV_B_W-1:0] b_q;
  logic               run_q;
  logic               active;
  logic               wrap_a;
  logic               wrap_b;
  strobe_t            strb;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= en_i;
  end

  // Counting only once run_q is set gives the first low phase its full length.
  assign active = run_q && en_i;

  scl_div_capture #(.AW(DIV_A_W), .BW(DIV_B_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
    .a_i(div_a_i), .b_i(div_b_i), .a_q(a_q), .b_q(b_q)
  );

  scl_prescale_stage #(.W(DIV_A_W)) u_stage_a (
    .clk(clk), .rst_n(rst_n), .clr_i(!active),
    .step_i(active), .limit_i(a_q), .wrap_o(wrap_a)
  );

  scl_prescale_stage #(.W(DIV_B_W)) u_stage_b (
    .clk(clk), .rst_n(rst_n), .clr_i(!active),
    .step_i(wrap_a), .limit_i(b_q), .wrap_o(wrap_b)
  );

  scl_phase_seq #(.LOW(LOW_TICKS), .HIGH(HIGH_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run_q), .active_i(active),
    .tick_i(wrap_b), .strb_o(strb), .scl_o(scl_o)
  );

  assign tick_o   = strb.tick;
  assign fall_o   = strb.fall;
  assign drive_o  = strb.drive;
  assign rise_o   = strb.rise;
  assign sample_o = strb.sample;
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
  import scl_rate_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               en_i,
  input logic               busy_i,
  input logic [DIV_A_W-1:0] div_a_i,
  input logic [DIV_B_W-1:0] div_b_i,
  input logic               scl_o,
  input logic               tick_o,
  input logic               fall_o,
  input logic               drive_o,
  input logic               rise_o,
  input logic               sample_o
);
  // R2: a disabled generator leaves the line high
  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> scl_o);

  // R2: a disabled generator emits no strobe
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !(tick_o || fall_o || drive_o || rise_o || sample_o));

  // R9: phase strobes never overlap
  p_strobe_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_o, drive_o, rise_o, sample_o}));

  // R4: line level agrees with the edge strobes
  p_rise_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> scl_o);
  p_fall_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !scl_o);

  // R6: each phase strobe sits on a base tick
  p_strobe_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o || drive_o || rise_o || sample_o) |-> tick_o);

  // R4: the line only rises on a rise strobe or when leaving the enabled state
  p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !scl_o) |=> (scl_o |-> rise_o));
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (.*);

// File: tb/sim_scl_rate_gen.sv
module sim_scl_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_i = 1'b0;
  logic       busy_i = 1'b0;
  logic [1:0] div_a_i = '0;
  logic [5:0] div_b_i = '0;
  logic       scl_o, tick_o, fall_o, drive_o, rise_o, sample_o;

  int  checks = 0;
  int  errors = 0;
  int  overlap_seen = 0;
  longint cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  scl_rate_gen u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .busy_i(busy_i),
    .div_a_i(div_a_i), .div_b_i(div_b_i), .scl_o(scl_o), .tick_o(tick_o),
    .fall_o(fall_o), .drive_o(drive_o), .rise_o(rise_o), .sample_o(sample_o)
  );

  // R9 monitor
  always @(negedge clk)
    if (rst_n && (int'(fall_o) + int'(drive_o) + int'(rise_o) + int'(sample_o)) > 1)
      overlap_seen++;

  function automatic longint per(input int a, input int b);
    return longint'((a + 1) * (b + 1));
  endfunction

  function automatic bit sel(input int which);
    case (which)
      0: return !scl_o;
      1: return tick_o;
      2: return fall_o;
      3: return drive_o;
      4: return rise_o;
      default: return sample_o;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_sig(input int which, output longint t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sel(which) && n < WAIT_LIMIT);
    t = cyc;
  endtask

  task automatic set_div(input int a, input int b);
    @(negedge clk);
    en_i = 1'b0; busy_i = 1'b0;
    div_a_i = 2'(a); div_b_i = 6'(b);
    repeat (3) @(negedge clk);
  endtask

  // Full timing check from enable for divisors a, b
  task automatic run_cfg(input int a, input int b);
    longint p, t0, td, tr, ts, tf, tf2, tt;
    p = per(a, b);
    set_div(a, b);
    busy_i = 1'b1;
    en_i = 1'b1;
    wait_sig(0, t0);
    wait_sig(3, td);
    chk(td - t0 == 5 * p, "R8 first drive", td - t0, 5 * p);
    wait_sig(4, tr);
    chk(tr - t0 == 11 * p, "R8 first rise", tr - t0, 11 * p);
    wait_sig(5, ts);
    chk(ts - tr == 5 * p, "R5 sample after rise", ts - tr, 5 * p);
    wait_sig(2, tf);
    chk(tf - tr == 11 * p, "R4 high phase", tf - tr, 11 * p);
    wait_sig(1, tt);
    chk(tt - tf == p, "R6 tick spacing", tt - tf, p);
    wait_sig(2, tf2);
    chk(tf2 - tf == 22 * p, "R3 period", tf2 - tf, 22 * p);
    if (a == 0 && b == 0) chk(tf2 - tf == 22, "R10 fastest period", tf2 - tf, 22);
  endtask

  initial begin
    longint tf, tf2, t0, tr;
    bit quiet;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk(scl_o == 1'b1 && !(tick_o | fall_o | drive_o | rise_o | sample_o),
        "R1 reset state", {scl_o, tick_o, fall_o}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scl_o == 1'b1 && !(tick_o | fall_o | rise_o), "R1 after reset", scl_o, 1);

    // R2: disabled for a while, divisors fastest
    quiet = 1'b1;
    div_a_i = 0; div_b_i = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (!scl_o || tick_o || fall_o || drive_o || rise_o || sample_o) quiet = 1'b0;
    end
    chk(quiet, "R2 disabled quiet", quiet, 1);

    // Directed corners incl. R10
    run_cfg(0, 0);
    run_cfg(3, 63);
    run_cfg(1, 0);
    run_cfg(0, 5);

    // Random configurations
    for (int k = 0; k < 8; k++) run_cfg(int'($urandom_range(0, 3)), int'($urandom_range(0, 40)));

    // R2 after running: drop enable mid-period
    @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    quiet = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (!scl_o || tick_o || fall_o || drive_o || rise_o || sample_o) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R2 quiet after disable", quiet, 1);

    // R7: changes while busy are ignored
    set_div(1, 2);
    busy_i = 1'b1;
    en_i = 1'b1;
    wait_sig(2, tf);
    div_a_i = 2'd3; div_b_i = 6'd9;
    wait_sig(2, tf2);
    chk(tf2 - tf == 22 * per(1, 2), "R7 busy holds period", tf2 - tf, 22 * per(1, 2));
    en_i = 1'b0;
    @(negedge clk);
    div_a_i = 2'd2; div_b_i = 6'd4;
    busy_i = 1'b0;
    @(negedge clk);
    busy_i = 1'b1;
    div_a_i = 2'd0; div_b_i = 6'd1;
    @(negedge clk);
    en_i = 1'b1;
    wait_sig(0, t0);
    wait_sig(4, tr);
    chk(tr - t0 == 11 * per(2, 4), "R7 captured when idle", tr - t0, 11 * per(2, 4));
    en_i = 1'b0;
    repeat (4) @(negedge clk);

    chk(overlap_seen == 0, "R9 strobe overlap", overlap_seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule